// File: doc/BRIEF.md
# Compare and Next-PC Unit

This block turns one 4-bit condition code into three results for a simple 32-bit processor. It gives a 0/1 word for compare instructions, a taken/not-taken decision for conditional branches, and the address of the next instruction. It keeps the program counter register itself. Each cycle it is shown the class of the instruction in flight, the register operand, a second operand (either a register value or a sign-extended immediate, chosen outside), the raw 16-bit immediate and the condition code.

One condition encoding serves both compares and branches. Bit 3 inverts the relation. Bit 2 swaps the second operand for zero. Bits 1:0 pick the base relation: none, equal, less-than or less-or-equal. The PC advances only when the `advance` input is high, so the surrounding sequencer can hold an instruction for several cycles. Every input and output is a plain control or data pin. No stream crosses the block's edge, so there is no valid/ready handshake.

Top module: `cmp_npc_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `pc` reads 0x00000040.
- R2: At a clock edge with `advance` high, `pc` takes the value `next_pc` had before that edge. With `advance` low, `pc` keeps its value.
- R3: `cmp_result` is 1 when the selected condition holds and 0 otherwise. Bits 31:1 are always zero.
- R4: The codes 0001 EQ, 0010 LT, 0011 LTE, 1001 NE, 1010 GTE and 1011 GT compare `rs_val` with `opnd_b` as signed two's-complement numbers.
- R5: The codes 0101 EQZ, 0110 LTZ, 0111 LTEZ, 1101 NEZ, 1110 GTEZ and 1111 GTZ compare `rs_val` with zero, signed. `opnd_b` has no effect on them.
- R6: Code 0000 (F) never holds and code 1000 (T) always holds. The unused codes 0100 and 1100 never hold.
- R7: For class 00 (sequential) and class 01 (compare), `next_pc` = `pc` + 4.
- R8: For class 10 (branch), `br_taken` equals the condition. `next_pc` = `pc` + 4 + sext(`imm`)×4 when the branch is taken, and `pc` + 4 when it is not.
- R9: For class 11 (jump-and-link), `next_pc` = `rs_val` + sext(`imm`)×4, using `rs_val` as presented in that cycle. `link_val` = `pc` + 4 for every class, so a jump whose destination register is also its base register is still well defined.
- R10: `br_taken` is 0 for every class other than branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Load `next_pc` into the PC at this edge |
| iclass | input | 2 | 00 sequential, 01 compare, 10 branch, 11 jump-and-link |
| cond | input | 4 | Condition code |
| rs_val | input | 32 | First operand and jump base |
| opnd_b | input | 32 | Second operand (register or extended immediate) |
| imm | input | 16 | Raw immediate for offsets |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address of the next instruction |
| link_val | output | 32 | Return address, `pc` + 4 |
| cmp_result | output | 32 | Compare result, 0 or 1 |
| br_taken | output | 1 | Branch decision |

## Verification
The bench builds the block with its defaults: 32-bit data, a 16-bit immediate, signed comparison and a reset PC of 0x40. The full 32-bit width lets the bench place the signed extremes 0x80000000 and 0x7FFFFFFF side by side. An unsigned or narrowed comparator gives the wrong answer there. The 16-bit immediate reaches the largest forward and backward branch and jump offsets, including 0x8000. A behavioural reference model tracks the PC and predicts all five outputs every cycle.

// File: rtl/cnpu_pkg.sv
package cnpu_pkg;
  typedef enum logic [1:0] {
    IC_SEQ = 2'b00,
    IC_CMP = 2'b01,
    IC_BR  = 2'b10,
    IC_JAL = 2'b11
  } iclass_e;

  typedef enum logic [1:0] {
    REL_NONE = 2'b00,
    REL_EQ   = 2'b01,
    REL_LT   = 2'b10,
    REL_LE   = 2'b11
  } rel_e;
endpackage

// File: rtl/cnpu_cond_eval.sv
module cnpu_cond_eval #(
  parameter int W          = 32,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   cond,
  output logic         holds
);
  import cnpu_pkg::*;

  logic [W-1:0] rhs;
  logic         is_eq;
  logic         is_lt;
  logic         base;
  logic         unused_code;
  rel_e         rel;

  // bit 2 replaces the second operand with zero
  assign rhs   = cond[2] ? '0 : b;
  assign is_eq = (a == rhs);

  generate
    if (SIGNED_CMP) begin : g_signed
      assign is_lt = ($signed(a) < $signed(rhs));
    end else begin : g_unsigned
      assign is_lt = (a < rhs);
    end
  endgenerate

  assign rel = rel_e'(cond[1:0]);

  always_comb begin
    case (rel)
      REL_EQ:  base = is_eq;
      REL_LT:  base = is_lt;
      REL_LE:  base = is_lt | is_eq;
      default: base = 1'b0;
    endcase
  end

  // zero-form with no relation has no meaning: evaluates false
  assign unused_code = cond[2] & (cond[1:0] == 2'b00);
  assign holds       = ~unused_code & (base ^ cond[3]);
endmodule

// File: rtl/cnpu_next_pc.sv
module cnpu_next_pc #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [W-1:0]     pc,
  input  logic [W-1:0]     rs_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [1:0]       iclass,
  input  logic             taken,
  output logic [W-1:0]     next_pc,
  output logic [W-1:0]     link_val
);
  import cnpu_pkg::*;

  localparam int EXT_W = W - IMM_W - 2;

  logic [W-1:0] word_off;
  logic [W-1:0] seq_pc;
  logic [W-1:0] br_pc;
  logic [W-1:0] jmp_pc;

  assign word_off = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign seq_pc   = pc + W'(4);
  assign br_pc    = seq_pc + word_off;
  assign jmp_pc   = rs_val + word_off;
  assign link_val = seq_pc;

  always_comb begin
    case (iclass_e'(iclass))
      IC_BR:   next_pc = taken ? br_pc : seq_pc;
      IC_JAL:  next_pc = jmp_pc;
      default: next_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/cnpu_pc_reg.sv
module cnpu_pc_reg #(
  parameter int           W        = 32,
  parameter logic [W-1:0] RESET_PC = 32'h40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic [W-1:0] next_in,
  output logic [W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pc <= RESET_PC;
    else if (advance) pc <= next_in;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> pc == $past(next_in));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pc));
endmodule

// File: rtl/cmp_npc_unit.sv
module cmp_npc_unit #(
  parameter int           DATA_W     = 32,
  parameter int           IMM_W      = 16,
  parameter bit           SIGNED_CMP = 1'b1,
  parameter logic [DATA_W-1:0] RESET_PC = 32'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [1:0]        iclass,
  input  logic [3:0]        cond,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] next_pc,
  output logic [DATA_W-1:0] link_val,
  output logic [DATA_W-1:0] cmp_result,
  output logic              br_taken
);
  import cnpu_pkg::*;

  logic holds;

  cnpu_cond_eval #(.W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) u_eval (
    .a(rs_val), .b(opnd_b), .cond(cond), .holds(holds)
  );

  assign br_taken   = holds & (iclass_e'(iclass) == IC_BR);
  assign cmp_result = {{(DATA_W-1){1'b0}}, holds};

  cnpu_next_pc #(.W(DATA_W), .IMM_W(IMM_W)) u_npc (
    .pc(pc), .rs_val(rs_val), .imm(imm), .iclass(iclass),
    .taken(br_taken), .next_pc(next_pc), .link_val(link_val)
  );

  cnpu_pc_reg #(.W(DATA_W), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .advance(advance), .next_in(next_pc), .pc(pc)
  );

  p_reset_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc == RESET_PC);
  p_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iclass == 2'b00 || iclass == 2'b01) |-> next_pc == pc + DATA_W'(4));
  p_const_true_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'b1000 |-> cmp_result == DATA_W'(1));
  p_const_false_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'b0000 || cond == 4'b0100 || cond == 4'b1100) |-> cmp_result == '0);
  p_taken_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> iclass == 2'b10);
  p_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    link_val == pc + DATA_W'(4));
  p_untaken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iclass == 2'b10 && !br_taken) |-> next_pc == pc + DATA_W'(4));
endmodule

// File: tb/cmp_npc_unit_tb.sv
module cmp_npc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        advance = 1'b0;
  logic [1:0]  iclass = 2'b00;
  logic [3:0]  cond = 4'h0;
  logic [31:0] rs_val = '0;
  logic [31:0] opnd_b = '0;
  logic [15:0] imm = '0;
  logic [31:0] pc, next_pc, link_val, cmp_result;
  logic        br_taken;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] pc_m;

  always #5 clk = ~clk;

  cmp_npc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .advance(advance), .iclass(iclass), .cond(cond),
    .rs_val(rs_val), .opnd_b(opnd_b), .imm(imm), .pc(pc), .next_pc(next_pc),
    .link_val(link_val), .cmp_result(cmp_result), .br_taken(br_taken)
  );

  function automatic bit ref_cond(logic [3:0] c, logic [31:0] a, logic [31:0] b);
    int sa, sb;
    sa = int'(a);
    sb = int'(b);
    case (c)
      4'b0000: return 0;
      4'b1000: return 1;
      4'b0001: return sa == sb;
      4'b1001: return sa != sb;
      4'b0010: return sa < sb;
      4'b1010: return sa >= sb;
      4'b0011: return sa <= sb;
      4'b1011: return sa > sb;
      4'b0101: return sa == 0;
      4'b1101: return sa != 0;
      4'b0110: return sa < 0;
      4'b1110: return sa >= 0;
      4'b0111: return sa <= 0;
      4'b1111: return sa > 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, string field, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, field, act, exp);
    end
  endtask

  task automatic run(bit adv, logic [1:0] cls, logic [3:0] c, logic [31:0] a,
                     logic [31:0] b, logic [15:0] im, string tag);
    bit h;
    logic [31:0] off, seq, exp_next;
    @(negedge clk);
    advance = adv; iclass = cls; cond = c; rs_val = a; opnd_b = b; imm = im;
    #1;
    h   = ref_cond(c, a, b);
    off = 32'(int'($signed(im)) * 4);
    seq = pc_m + 32'd4;
    case (cls)
      2'b10:   exp_next = h ? seq + off : seq;
      2'b11:   exp_next = a + off;
      default: exp_next = seq;
    endcase
    chk(tag, "pc", pc, pc_m);
    chk(tag, "cmp_result", cmp_result, {31'b0, h});
    chk(tag, "br_taken", {31'b0, br_taken}, {31'b0, h && cls == 2'b10});
    chk(tag, "next_pc", next_pc, exp_next);
    chk(tag, "link_val", link_val, seq);
    @(posedge clk);
    if (adv) pc_m = exp_next;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pc_m = 32'h40;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 in reset", "pc", pc, 32'h40);
    rst_n = 1'b1;
    // R1 first cycle after release, advance low (R2 hold)
    run(0, 2'b00, 4'h0, 0, 0, 0, "R1 after reset");
    run(0, 2'b00, 4'h0, 0, 0, 0, "R2 hold");
    run(1, 2'b00, 4'h0, 0, 0, 0, "R7 sequential");
    run(1, 2'b01, 4'b0001, 32'd5, 32'd5, 0, "R3 R4 EQ equal");
    run(1, 2'b01, 4'b1001, 32'd5, 32'd5, 0, "R4 NE equal");
    run(1, 2'b01, 4'b0010, 32'h80000000, 32'h7FFFFFFF, 0, "R4 LT signed extreme");
    run(1, 2'b01, 4'b1011, 32'h7FFFFFFF, 32'h80000000, 0, "R4 GT signed extreme");
    run(1, 2'b01, 4'b0011, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, "R4 LTE equal");
    run(1, 2'b01, 4'b1010, 32'hFFFFFFFE, 32'hFFFFFFFF, 0, "R4 GTE below");
    run(1, 2'b01, 4'b0101, 32'd0, 32'd9, 0, "R5 EQZ ignores b");
    run(1, 2'b01, 4'b0110, 32'hFFFFFFFF, 32'h80000000, 0, "R5 LTZ");
    run(1, 2'b01, 4'b0111, 32'd0, 32'hFFFFFFFF, 0, "R5 LTEZ zero");
    run(1, 2'b01, 4'b1111, 32'd1, 32'd100, 0, "R5 GTZ ignores b");
    run(1, 2'b01, 4'b1110, 32'h80000000, 32'd0, 0, "R5 GTEZ most negative");
    run(1, 2'b01, 4'b1101, 32'd0, 32'd3, 0, "R5 NEZ zero");
    run(1, 2'b01, 4'b0000, 32'd1, 32'd1, 0, "R6 F");
    run(1, 2'b01, 4'b1000, 32'd1, 32'd2, 0, "R6 T");
    run(1, 2'b01, 4'b0100, 32'd0, 32'd0, 0, "R6 unused 0100");
    run(1, 2'b01, 4'b1100, 32'd0, 32'd0, 0, "R6 unused 1100");
    run(1, 2'b10, 4'b0001, 32'd7, 32'd7, 16'h0010, "R8 branch taken fwd");
    run(1, 2'b10, 4'b0001, 32'd7, 32'd8, 16'h0010, "R8 branch not taken");
    run(1, 2'b10, 4'b1000, 0, 0, 16'hFFF0, "R8 branch taken back");
    run(1, 2'b00, 4'b1000, 0, 0, 16'h0100, "R10 T on sequential");
    run(1, 2'b11, 4'b1000, 32'h00001000, 0, 16'h8000, "R9 R10 JAL min offset");
    run(1, 2'b11, 4'h0, pc_m, 0, 16'h0000, "R9 JAL base equals pc");
    run(1, 2'b11, 4'h0, 32'h200, 0, 16'h7FFF, "R9 JAL max offset");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom % 4 == 0) ? a : $urandom;
      if ($urandom % 5 == 0) a = 0;
      run(bit'($urandom % 4 != 0), 2'($urandom), 4'($urandom), a, b, 16'($urandom),
          "R2 R3 R4 R5 R8 R9 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule